// File: doc/BRIEF.md
# Gate Driver Switching Sequencer

This block steps the output stage of an isolated gate driver through its turn-on and turn-off sequences. A PWM command selects the wanted state. Turn-on is either hard, or two-level with a programmable plateau at an intermediate gate level. Turn-off is two-level as well. A regular turn-off, caused by the PWM command falling, and a safe turn-off, caused by a safe-off request, each take their plateau length from a register of their own. An emergency request forces the gate off at once from any state.

An active-clamp output is normally asserted. A mode bit selects whether it is released for a programmed time at the start of every turn-off, or only at the start of an emergency turn-off. A pulse suppressor can be enabled so that a turn-on command arriving during a turn-off plateau waits until the plateau ends.

All delays count ticks of an internal timebase of `PRESCALE` clock cycles. A four-register write port sets the configuration. The secondary register is write-protected by an enable bit in the primary one.

Top module: `gdrv_sequencer`

## Requirements
- R1: After synchronous active-low reset, `gateLvl` is 0 (off) and `clampAct` is 1. Every delay register is zero, so the first turn-on is hard and a clamp release lasts zero cycles.
- R2: `gateLvl` encodes 0 = off, 1 = intermediate, 2 = full on. With the turn-on delay at zero, a rising PWM command takes the gate straight from 0 to 2 in the next cycle.
- R3: With a turn-on delay N > 0 (address 1, bits [DLYW-1:0]), the gate shows level 1 for N*PRESCALE cycles starting the cycle after the command, and then level 2.
- R4: When PWM falls from full on, the gate holds level 1 for R*PRESCALE cycles, where R is the regular delay (address 2), and then goes to 0. With R = 0 it goes to 0 in the next cycle.
- R5: A safe-off request during full on gives level 1 for S*PRESCALE cycles, where S is the safe delay (address 3), and then 0. Turn-on stays blocked while the request is held.
- R6: An asserted emergency request forces `gateLvl` to 0 in the next cycle from any state, including a turn-on plateau, and blocks turn-on while it is held.
- R7: With the clamp mode bit clear (address 1, bit DLYW), every turn-off start drops `clampAct` for C*PRESCALE cycles, where C is address 0 bits [CLMPW+1:2].
- R8: With the clamp mode bit set, regular and safe turn-offs leave `clampAct` at 1, and only an emergency turn-off from a non-off state releases it.
- R9: Writes to address 1 are ignored unless address 0 bit 0 (write enable) is already set.
- R10: With the suppressor enabled (address 0 bit 1), a PWM rise during a turn-off plateau leaves level 1 until the plateau expires. The gate then shows one cycle at 0 before turn-on begins.
- R11: With the suppressor disabled, a PWM rise during a regular turn-off plateau returns the gate to level 2 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pwmCmd | input | 1 | Wanted gate state, 1 = on |
| safeOff | input | 1 | Safe turn-off request, level sensitive |
| emergOff | input | 1 | Emergency turn-off request, level sensitive |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address 0..3 |
| wrData | input | DATAW (6) | Register write data |
| gateLvl | output | 2 | Gate stage level, 0 off / 1 intermediate / 2 full |
| clampAct | output | 1 | Active clamp, 1 = active |

## Verification
Each command or request is taken at the first clock edge after it is driven, and its first new level shows up immediately after that edge. A plateau of D ticks therefore covers exactly D*PRESCALE samples, and the clamp release counts the same way. The bench drives inputs on falling edges and samples once per cycle on later falling edges. It counts the samples spent at each level and with the clamp low, and checks the first and last sample of each window, so an off-by-one in any timer changes a count. Register writes take effect at the edge inside the write task, before any stimulus that relies on them.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_FULL = 2'd2
  } gateLvl_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TON  = 2'd1,
    ST_ON   = 2'd2,
    ST_TOFF = 2'd3
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadTon;
    logic loadReg;
    logic loadSafe;
    logic clampGo;
    logic emergGo;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tonZero;
    logic regZero;
    logic safeZero;
    logic psupEn;
    logic clampMode;
    logic seqLast;
  } seqStat_t;
endpackage

// File: rtl/gdrv_tick_timer.sv
module gdrv_tick_timer #(
  parameter int PRESCALE = 4,
  parameter int W        = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         last
);
  localparam int PREW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PREW-1:0] PRE_MAX = PREW'(PRESCALE - 1);

  logic [W-1:0]    rem;
  logic [PREW-1:0] pre;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem <= '0;
      pre <= '0;
    end else if (load) begin
      rem <= loadVal;
      pre <= '0;
    end else if (rem != '0) begin
      if (pre == PRE_MAX) begin
        pre <= '0;
        rem <= rem - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  // high in the final cycle of the programmed window
  assign last = (rem == W'(1)) && (pre == PRE_MAX);
endmodule

// File: rtl/gdrv_dpath.sv
module gdrv_dpath
  import gdrv_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DLYW     = 4,
  parameter int CLMPW    = 4,
  parameter int DATAW    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [DATAW-1:0] wrData,
  input  seqStrobe_t       strobe,
  output seqStat_t         stat,
  output logic             clampAct
);
  logic             cfg2En;
  logic             psupEn;
  logic [CLMPW-1:0] clampDly;
  logic [DLYW-1:0]  tonDly;
  logic             clampMode;
  logic [DLYW-1:0]  regDly;
  logic [DLYW-1:0]  safeDly;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg2En    <= 1'b0;
      psupEn    <= 1'b0;
      clampDly  <= '0;
      tonDly    <= '0;
      clampMode <= 1'b0;
      regDly    <= '0;
      safeDly   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0: begin
          cfg2En   <= wrData[0];
          psupEn   <= wrData[1];
          clampDly <= wrData[CLMPW+1:2];
        end
        2'd1: begin
          if (cfg2En) begin
            tonDly    <= wrData[DLYW-1:0];
            clampMode <= wrData[DLYW];
          end
        end
        2'd2:    regDly  <= wrData[DLYW-1:0];
        default: safeDly <= wrData[DLYW-1:0];
      endcase
    end
  end

  // sequence plateau timer
  logic            seqLoad;
  logic [DLYW-1:0] seqVal;
  logic            seqLast;

  assign seqLoad = strobe.loadTon | strobe.loadReg | strobe.loadSafe;

  always_comb begin
    if (strobe.loadTon)      seqVal = tonDly;
    else if (strobe.loadReg) seqVal = regDly;
    else                     seqVal = safeDly;
  end

  gdrv_tick_timer #(.PRESCALE(PRESCALE), .W(DLYW)) seqTmr_i (
    .clk(clk), .rstN(rstN), .load(seqLoad), .loadVal(seqVal), .last(seqLast)
  );

  // clamp release timer
  logic clampLoad;
  logic clampLast;
  logic clampActQ;

  assign clampLoad = strobe.clampGo && (clampDly != '0);

  gdrv_tick_timer #(.PRESCALE(PRESCALE), .W(CLMPW)) clampTmr_i (
    .clk(clk), .rstN(rstN), .load(clampLoad), .loadVal(clampDly), .last(clampLast)
  );

  always_ff @(posedge clk) begin
    if (!rstN)          clampActQ <= 1'b1;
    else if (clampLoad) clampActQ <= 1'b0;
    else if (clampLast) clampActQ <= 1'b1;
  end

  assign clampAct = clampActQ;

  assign stat.tonZero   = (tonDly == '0);
  assign stat.regZero   = (regDly == '0);
  assign stat.safeZero  = (safeDly == '0);
  assign stat.psupEn    = psupEn;
  assign stat.clampMode = clampMode;
  assign stat.seqLast   = seqLast;

  // R9
  cfg2_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd1 && !cfg2En) |=> ($stable(tonDly) && $stable(clampMode)));

  // R7
  clamp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clampGo && clampDly != '0) |=> !clampAct);

  // R8
  clamp_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clampAct) |-> ($past(strobe.emergGo) || !$past(clampMode)));
endmodule

// File: rtl/gdrv_ctrl.sv
module gdrv_ctrl
  import gdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmCmd,
  input  logic       safeOff,
  input  logic       emergOff,
  input  seqStat_t   stat,
  output seqStrobe_t strobe,
  output logic [1:0] gateLvl
);
  seqState_e state, stateNxt;
  logic      offStart;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt        = state;
    strobe          = '0;
    offStart        = 1'b0;
    strobe.emergGo  = emergOff && (state != ST_OFF);
    case (state)
      ST_OFF: begin
        if (pwmCmd && !safeOff && !emergOff) begin
          if (stat.tonZero) begin
            stateNxt = ST_ON;
          end else begin
            stateNxt       = ST_TON;
            strobe.loadTon = 1'b1;
          end
        end
      end
      ST_TON: begin
        if (emergOff)          stateNxt = ST_OFF;
        else if (stat.seqLast) stateNxt = ST_ON;
      end
      ST_ON: begin
        if (emergOff) begin
          stateNxt = ST_OFF;
        end else if (safeOff) begin
          offStart        = 1'b1;
          stateNxt        = stat.safeZero ? ST_OFF : ST_TOFF;
          strobe.loadSafe = !stat.safeZero;
        end else if (!pwmCmd) begin
          offStart       = 1'b1;
          stateNxt       = stat.regZero ? ST_OFF : ST_TOFF;
          strobe.loadReg = !stat.regZero;
        end
      end
      default: begin
        if (emergOff)                                     stateNxt = ST_OFF;
        else if (pwmCmd && !safeOff && !stat.psupEn)      stateNxt = ST_ON;
        else if (stat.seqLast)                            stateNxt = ST_OFF;
      end
    endcase
    strobe.clampGo = strobe.emergGo || (offStart && !stat.clampMode);
  end

  always_comb begin
    case (state)
      ST_OFF:  gateLvl = LVL_OFF;
      ST_ON:   gateLvl = LVL_FULL;
      default: gateLvl = LVL_MID;
    endcase
  end

  // R6
  emerg_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    emergOff |=> (gateLvl == LVL_OFF));

  // R2
  hard_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && $past(state) == ST_OFF) |-> $past(stat.tonZero));

  // R3
  soft_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TON && $past(state) == ST_OFF) |-> !$past(stat.tonZero));

  // R10
  psup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TOFF && stat.psupEn && !stat.seqLast && !emergOff) |=> (state == ST_TOFF));

  // R11
  toff_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TOFF && !stat.psupEn && pwmCmd && !safeOff && !emergOff) |=> (gateLvl == LVL_FULL));
endmodule

// File: rtl/gdrv_sequencer.sv
module gdrv_sequencer
  import gdrv_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DLYW     = 4,
  parameter int CLMPW    = 4,
  localparam int DATAW   = ((CLMPW + 2) > (DLYW + 1)) ? (CLMPW + 2) : (DLYW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmCmd,
  input  logic             safeOff,
  input  logic             emergOff,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [DATAW-1:0] wrData,
  output logic [1:0]       gateLvl,
  output logic             clampAct
);
  seqStrobe_t strobe;
  seqStat_t   stat;

  gdrv_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .safeOff(safeOff),
    .emergOff(emergOff), .stat(stat), .strobe(strobe), .gateLvl(gateLvl)
  );

  gdrv_dpath #(.PRESCALE(PRESCALE), .DLYW(DLYW), .CLMPW(CLMPW), .DATAW(DATAW)) dpath_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .stat(stat), .clampAct(clampAct)
  );
endmodule

// File: tb/gdrv_sequencer_tb_top.sv
module gdrv_sequencer_tb_top;
  localparam int P  = 4;
  localparam int BW = 6;

  logic clk = 1'b0;
  logic rstN, pwmCmd, safeOff, emergOff, wrEn;
  logic [1:0] wrAddr;
  logic [BW-1:0] wrData;
  logic [1:0] gateLvl;
  logic clampAct;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  int firstLvl, lastLvl, cntOff, cntMid, cntFull, cntClampLow;

  always #10 clk = ~clk;

  gdrv_sequencer #(.PRESCALE(P), .DLYW(4), .CLMPW(4)) dut_i (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .safeOff(safeOff), .emergOff(emergOff),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .gateLvl(gateLvl), .clampAct(clampAct)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [BW-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // samples n cycles; raises pwm / emergency after sample index riseAt / emergAt
  task automatic window(input int n, input int riseAt, input int emergAt);
    cntOff = 0; cntMid = 0; cntFull = 0; cntClampLow = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) firstLvl = int'(gateLvl);
      lastLvl = int'(gateLvl);
      case (gateLvl)
        2'd0: cntOff++;
        2'd1: cntMid++;
        default: cntFull++;
      endcase
      if (!clampAct) cntClampLow++;
      if (i == riseAt)  pwmCmd = 1'b1;
      if (i == emergAt) emergOff = 1'b1;
    end
  endtask

  task automatic tReset();
    rstN = 1'b0; pwmCmd = 1'b0; safeOff = 1'b0; emergOff = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 gate off after reset", int'(gateLvl), 0);
    chk("R1 clamp active after reset", int'(clampAct), 1);
  endtask

  task automatic tHardAfterReset();
    pwmCmd = 1'b1;
    window(4, -1, -1);
    chk("R1 R2 hard turn-on first sample", firstLvl, 2);
    pwmCmd = 1'b0;
    window(6, -1, -1);
    chk("R4 zero regular delay immediate off", firstLvl, 0);
    chk("R1 cleared clamp time no release", cntClampLow, 0);
  endtask

  task automatic tWriteLock();
    wr(2'd0, 6'h00);
    wr(2'd1, 6'h03);
    pwmCmd = 1'b1;
    window(4, -1, -1);
    chk("R9 locked write ignored, still hard on", firstLvl, 2);
    pwmCmd = 1'b0;
    idle(4);
  endtask

  task automatic tSoftOn();
    wr(2'd0, 6'h15);   // enable, clamp time 5
    wr(2'd1, 6'h03);   // ton 3, mode 0
    wr(2'd2, 6'h02);   // regular 2
    wr(2'd3, 6'h01);   // safe 1
    pwmCmd = 1'b1;
    window(20, -1, -1);
    chk("R3 first sample intermediate", firstLvl, 1);
    chk("R3 plateau length", cntMid, 3 * P);
    chk("R3 ends full", lastLvl, 2);
  endtask

  task automatic tRegularOff();
    pwmCmd = 1'b0;
    window(30, -1, -1);
    chk("R4 first sample intermediate", firstLvl, 1);
    chk("R4 regular plateau length", cntMid, 2 * P);
    chk("R4 ends off", lastLvl, 0);
    chk("R7 clamp release on regular off", cntClampLow, 5 * P);
  endtask

  task automatic tSafeOff();
    pwmCmd = 1'b1;
    idle(20);
    safeOff = 1'b1;
    window(30, -1, -1);
    chk("R5 safe plateau length", cntMid, 1 * P);
    chk("R5 held request keeps off", lastLvl, 0);
    chk("R7 clamp release on safe off", cntClampLow, 5 * P);
    safeOff = 1'b0;
    window(20, -1, -1);
    chk("R5 turn-on after release", lastLvl, 2);
  endtask

  task automatic tClampMode1();
    wr(2'd1, 6'h13);   // mode 1, ton 3
    pwmCmd = 1'b0;
    window(30, -1, -1);
    chk("R8 no release on regular off", cntClampLow, 0);
    chk("R4 regular plateau with mode 1", cntMid, 2 * P);
    pwmCmd = 1'b1;
    idle(20);
    emergOff = 1'b1;
    window(30, -1, -1);
    chk("R6 emergency off next cycle", firstLvl, 0);
    chk("R6 stays off while held", cntOff, 30);
    chk("R8 release on emergency", cntClampLow, 5 * P);
    emergOff = 1'b0;
    window(20, -1, -1);
    chk("R6 turn-on after release", lastLvl, 2);
  endtask

  task automatic tEmergInPlateau();
    pwmCmd = 1'b0;
    idle(20);
    pwmCmd = 1'b1;
    window(6, -1, 2);
    chk("R6 plateau before emergency", cntMid, 3);
    chk("R6 emergency ends plateau", lastLvl, 0);
    emergOff = 1'b0;
    pwmCmd = 1'b0;
    idle(4);
  endtask

  task automatic tSuppressor();
    wr(2'd0, 6'h17);   // enable, suppressor, clamp 5
    wr(2'd1, 6'h00);   // ton 0, mode 0
    wr(2'd2, 6'h03);   // regular 3
    pwmCmd = 1'b1;
    idle(4);
    pwmCmd = 1'b0;
    window(20, 3, -1);
    chk("R10 plateau not cut", cntMid, 3 * P);
    chk("R10 one off cycle", cntOff, 1);
    chk("R10 ends full", lastLvl, 2);
    wr(2'd0, 6'h15);   // suppressor off
    pwmCmd = 1'b0;
    window(20, 3, -1);
    chk("R11 plateau cut", cntMid, 4);
    chk("R11 no off cycle", cntOff, 0);
    chk("R11 ends full", lastLvl, 2);
  endtask

  initial begin
    tReset();
    tHardAfterReset();
    tWriteLock();
    tSoftOn();
    tRegularOff();
    tSafeOff();
    tClampMode1();
    tEmergInPlateau();
    tSuppressor();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule